// File: doc/BRIEF.md
# Instruction Decoder with Legality Checks

This block is a purely combinational decoder for a 32-bit instruction word in a three-format encoding. Every format keeps the operation code in the top six bits. The register-format word carries three 5-bit register fields and a 5-bit shift amount. The immediate-format word carries two register fields and a 16-bit constant. The jump format carries a 26-bit address. The decoder slices these fields out, sorts the operation code into a format class, and produces read-port, write-port, memory and control strobes for the execution units.

Legality is judged per operation. Each operation defines, for each register field, whether the field is required, optional, must be empty, or is not a register field at all. An empty field holds the placeholder code 0x1F. A malformed word raises `illegal`. A word that is well formed but names a privileged register outside kernel mode, or writes the program counter, raises `prot_fault`. When either flag is raised, every strobe is withheld. The decoder holds no state: its outputs follow the instruction word and the kernel-mode input.

Register codes: 0x00-0x0F general purpose, 0x10 accumulator, 0x11 stack pointer, 0x12 frame pointer, 0x13 return address, 0x14 and 0x15 privileged table pointers, 0x16 constant zero, 0x17 program counter, 0x18-0x1E undefined, 0x1F empty.

The field usage per operation code is given below. Field A is bits 25:21, field B is bits 20:16 and field C is bits 15:11. In each entry, "rd" means the field feeds a read port and "wr" means it names the write register.
- Register-format operations:
  - 0x00, 0x23, 0x24: all three fields empty.
  - 0x01, 0x02, 0x1D: A rd, B empty, C wr.
  - 0x14: A and B rd, C empty.
  - 0x15, 0x16: A and B empty, C rd and wr.
  - 0x17, 0x18: A empty, B optional rd (the amount register), C rd and wr.
  - 0x19-0x1C and 0x1E-0x21: A and B rd, C wr.
- Immediate-format operations:
  - 0x03-0x07: A rd, B wr.
  - 0x08-0x0A: A rd (the data), B rd (the base).
  - 0x0B: A empty, B wr.
  - 0x0C: A empty, B rd and wr.
  - 0x0D-0x13: A optional rd, B empty.
  - 0x22: A and B empty.
  - 0x25, 0x26: A rd, B wr.

Top module: `instr_decode`

## Requirements
- R1: `opcode` is bits 31:26, `shamt` is bits 10:6, `imm` is bits 15:0 and `jaddr` is bits 25:0. `fmt` is 2'b00 for register-format opcodes (0x00-0x02, 0x14-0x21, 0x23, 0x24), 2'b01 for immediate-format opcodes (0x03-0x13, 0x22, 0x25, 0x26) and 2'b11 for opcodes 0x27-0x3F.
- R2: Any opcode from 0x27 to 0x3F raises `illegal`.
- R3: On a register-format opcode other than 0x17 and 0x18, a nonzero shift amount raises `illegal`. On immediate-format words, bits 10:6 belong to the constant and are not checked.
- R4: A field that must be empty but does not hold 0x1F raises `illegal`. A required field that holds 0x1F also raises `illegal`.
- R5: A used field (required, or optional and not 0x1F) that holds a code from 0x18 to 0x1E raises `illegal`.
- R6: With `kernel_mode` low, a used field that holds 0x14 or 0x15 raises `prot_fault`. With `kernel_mode` high, it does not.
- R7: A write field that holds 0x17 raises `prot_fault`. Reading 0x17 is allowed.
- R8: When `illegal` is raised, `prot_fault` is low.
- R9: While either flag is raised, `rd_a_en`, `rd_b_en`, `wr_en`, `mem_rd`, `mem_wr`, `branch` and `halt` are low and `rd_a`, `rd_b`, `wr_reg` read 0x1F.
- R10: Opcodes 0x03-0x07 assert `mem_rd` and 0x08-0x0A assert `mem_wr`. `mem_size` is 0 for a byte, 1 for a halfword and 2 for a word. `mem_sext` is 1 only for 0x04 and 0x06. Without a memory strobe, both `mem_size` and `mem_sext` are 0.
- R11: `rd_a`, `rd_b` and `wr_reg` follow the usage table, each with its enable set only when the chosen field is not 0x1F. A disabled port reads 0x1F.
- R12: Shift opcodes take their amount either from field B or from the shift field. Naming a register in B together with a nonzero shift amount raises `illegal`.
- R13: Opcode 0x22 carries an 8-bit code: nonzero bits 15:8 raise `illegal`.
- R14: Opcodes 0x0D-0x13 assert `branch` and opcode 0x24 asserts `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| kernel_mode | input | 1 | High when privileged registers may be named |
| opcode | output | 6 | Operation code field |
| fmt | output | 2 | Format class: 0 register, 1 immediate, 3 undefined |
| shamt | output | 5 | Shift amount field |
| imm | output | 16 | Immediate field |
| jaddr | output | 26 | Jump address field |
| rd_a | output | 5 | First read register |
| rd_a_en | output | 1 | First read port in use |
| rd_b | output | 5 | Second read register |
| rd_b_en | output | 1 | Second read port in use |
| wr_reg | output | 5 | Write register |
| wr_en | output | 1 | Register write requested |
| mem_rd | output | 1 | Load |
| mem_wr | output | 1 | Store |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_sext | output | 1 | Load result is sign extended |
| branch | output | 1 | Jump operation |
| halt | output | 1 | Halt operation |
| illegal | output | 1 | Malformed encoding |
| prot_fault | output | 1 | Access-rights violation |

## Verification
The embedded assertions check the properties that hold for every word on every evaluation:
- The two flags never coincide.
- Every strobe is withheld while a flag is raised.
- A load and a store never appear together.
- No enabled write names the program counter.
- No enabled read port names a privileged register outside kernel mode.
- An undefined opcode is always flagged.

Whether a particular field layout is judged correctly per opcode can only be shown by the bench's vectors. The same holds for the chosen port mapping, access size and sign extension, and for the corner cases: the optional shift and jump registers, undefined register codes, and constant bits that overlap the shift field.

// File: rtl/instr_decode.sv
module instr_decode (
  input  logic [31:0] instr,
  input  logic        kernel_mode,
  output logic [5:0]  opcode,
  output logic [1:0]  fmt,
  output logic [4:0]  shamt,
  output logic [15:0] imm,
  output logic [25:0] jaddr,
  output logic [4:0]  rd_a,
  output logic        rd_a_en,
  output logic [4:0]  rd_b,
  output logic        rd_b_en,
  output logic [4:0]  wr_reg,
  output logic        wr_en,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [1:0]  mem_size,
  output logic        mem_sext,
  output logic        branch,
  output logic        halt,
  output logic        illegal,
  output logic        prot_fault
);
  localparam logic [4:0] NOREG = 5'h1F;
  localparam logic [4:0] R_TBL0 = 5'h14;
  localparam logic [4:0] R_TBL1 = 5'h15;
  localparam logic [4:0] R_PC = 5'h17;
  localparam logic [1:0] FMT_R = 2'd0, FMT_I = 2'd1, FMT_X = 2'd3;
  localparam logic [1:0] U_NONE = 2'd0, U_REQ = 2'd1, U_OPT = 2'd2, U_IGN = 2'd3;
  localparam logic [1:0] S_NONE = 2'd0, S_A = 2'd1, S_B = 2'd2, S_C = 2'd3;

  logic [4:0] fa, fb, fc;
  logic [1:0] ua, ub, uc, sa, sb, sw, size;
  logic       ld, st, br_op, hlt_op, sx, shift_op, int_op, bad_op;
  logic       ill_raw, prot_raw, ok;

  assign opcode = instr[31:26];
  assign fa     = instr[25:21];
  assign fb     = instr[20:16];
  assign fc     = instr[15:11];
  assign shamt  = instr[10:6];
  assign imm    = instr[15:0];
  assign jaddr  = instr[25:0];

  function automatic logic live(input logic [4:0] c, input logic [1:0] u);
    return (u == U_REQ) || (u == U_OPT && c != NOREG);
  endfunction

  function automatic logic fbad(input logic [4:0] c, input logic [1:0] u);
    return (u == U_NONE && c != NOREG) || (u == U_REQ && c == NOREG) ||
           (live(c, u) && c >= 5'h18 && c <= 5'h1E);
  endfunction

  function automatic logic fprot(input logic [4:0] c, input logic [1:0] u,
                                 input logic wr, input logic kern);
    return live(c, u) && (((c == R_TBL0 || c == R_TBL1) && !kern) || (wr && c == R_PC));
  endfunction

  function automatic logic [4:0] pick(input logic [1:0] s, input logic [4:0] a,
                                      input logic [4:0] b, input logic [4:0] c);
    case (s)
      S_A:     return a;
      S_B:     return b;
      S_C:     return c;
      default: return NOREG;
    endcase
  endfunction

  always_comb begin
    fmt = FMT_R;
    ua = U_NONE; ub = U_NONE; uc = U_NONE;
    sa = S_NONE; sb = S_NONE; sw = S_NONE;
    ld = 1'b0; st = 1'b0; br_op = 1'b0; hlt_op = 1'b0;
    size = 2'd0; sx = 1'b0; shift_op = 1'b0; int_op = 1'b0; bad_op = 1'b0;
    case (opcode) inside
      6'h00, 6'h23: ;
      6'h24: hlt_op = 1'b1;
      6'h01, 6'h02, 6'h1D: begin
        ua = U_REQ; uc = U_REQ; sa = S_A; sw = S_C;
      end
      [6'h03:6'h07]: begin
        fmt = FMT_I; ua = U_REQ; ub = U_REQ; uc = U_IGN; sa = S_A; sw = S_B;
        ld = 1'b1;
        size = (opcode == 6'h07) ? 2'd2 : (opcode >= 6'h05) ? 2'd1 : 2'd0;
        sx = (opcode == 6'h04) || (opcode == 6'h06);
      end
      [6'h08:6'h0A]: begin
        fmt = FMT_I; ua = U_REQ; ub = U_REQ; uc = U_IGN; sa = S_A; sb = S_B;
        st = 1'b1; size = opcode[1:0];
      end
      6'h0B: begin
        fmt = FMT_I; ub = U_REQ; uc = U_IGN; sw = S_B;
      end
      6'h0C: begin
        fmt = FMT_I; ub = U_REQ; uc = U_IGN; sa = S_B; sw = S_B;
      end
      [6'h0D:6'h13]: begin
        fmt = FMT_I; ua = U_OPT; uc = U_IGN; sa = S_A; br_op = 1'b1;
      end
      6'h14: begin
        ua = U_REQ; ub = U_REQ; sa = S_A; sb = S_B;
      end
      6'h15, 6'h16: begin
        uc = U_REQ; sa = S_C; sw = S_C;
      end
      6'h17, 6'h18: begin
        ub = U_OPT; uc = U_REQ; sa = S_C; sb = S_B; sw = S_C; shift_op = 1'b1;
      end
      [6'h19:6'h1C], [6'h1E:6'h21]: begin
        ua = U_REQ; ub = U_REQ; uc = U_REQ; sa = S_A; sb = S_B; sw = S_C;
      end
      6'h22: begin
        fmt = FMT_I; uc = U_IGN; int_op = 1'b1;
      end
      6'h25, 6'h26: begin
        fmt = FMT_I; ua = U_REQ; ub = U_REQ; uc = U_IGN; sa = S_A; sw = S_B;
      end
      default: begin
        fmt = FMT_X; ua = U_IGN; ub = U_IGN; uc = U_IGN; bad_op = 1'b1;
      end
    endcase
  end

  assign ill_raw = bad_op || fbad(fa, ua) || fbad(fb, ub) || fbad(fc, uc) ||
                   (fmt == FMT_R && !shift_op && shamt != 5'd0) ||
                   (shift_op && fb != NOREG && shamt != 5'd0) ||
                   (int_op && imm[15:8] != 8'd0);
  assign prot_raw = fprot(fa, ua, sw == S_A, kernel_mode) ||
                    fprot(fb, ub, sw == S_B, kernel_mode) ||
                    fprot(fc, uc, sw == S_C, kernel_mode);
  assign ok         = !ill_raw && !prot_raw;
  assign illegal    = ill_raw;
  assign prot_fault = prot_raw && !ill_raw;

  assign rd_a_en  = ok && sa != S_NONE && pick(sa, fa, fb, fc) != NOREG;
  assign rd_b_en  = ok && sb != S_NONE && pick(sb, fa, fb, fc) != NOREG;
  assign wr_en    = ok && sw != S_NONE && pick(sw, fa, fb, fc) != NOREG;
  assign rd_a     = rd_a_en ? pick(sa, fa, fb, fc) : NOREG;
  assign rd_b     = rd_b_en ? pick(sb, fa, fb, fc) : NOREG;
  assign wr_reg   = wr_en ? pick(sw, fa, fb, fc) : NOREG;
  assign mem_rd   = ok && ld;
  assign mem_wr   = ok && st;
  assign mem_size = (mem_rd || mem_wr) ? size : 2'd0;
  assign mem_sext = mem_rd && sx;
  assign branch   = ok && br_op;
  assign halt     = ok && hlt_op;

  always_comb begin
    assert_flag_priority_R8: assert (!(illegal && prot_fault))
      else $error("both flags raised");
    assert_strobes_quiet_R9: assert (!(illegal || prot_fault) ||
      !(rd_a_en || rd_b_en || wr_en || mem_rd || mem_wr || branch || halt))
      else $error("strobe while flagged");
    assert_mem_exclusive_R10: assert (!(mem_rd && mem_wr))
      else $error("load and store together");
    assert_no_pc_write_R7: assert (!(wr_en && wr_reg == R_PC))
      else $error("program counter written");
    assert_priv_read_R6: assert (kernel_mode ||
      !((rd_a_en && (rd_a == R_TBL0 || rd_a == R_TBL1)) ||
        (rd_b_en && (rd_b == R_TBL0 || rd_b == R_TBL1))))
      else $error("privileged read in user mode");
    assert_undef_op_R2: assert (opcode <= 6'h26 || illegal)
      else $error("undefined opcode not flagged");
  end
endmodule

// File: tb/tb_instr_decode.sv
module tb_instr_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] N = 5'h1F;
  localparam logic [1:0] FR = 2'd0, FI = 2'd1, FX = 2'd3;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] instr;
  logic        kernel_mode;
  logic [5:0]  opcode;
  logic [1:0]  fmt, mem_size;
  logic [4:0]  shamt, rd_a, rd_b, wr_reg;
  logic [15:0] imm;
  logic [25:0] jaddr;
  logic rd_a_en, rd_b_en, wr_en, mem_rd, mem_wr, mem_sext, branch, halt, illegal, prot_fault;

  instr_decode dut (
    .instr(instr), .kernel_mode(kernel_mode), .opcode(opcode), .fmt(fmt), .shamt(shamt),
    .imm(imm), .jaddr(jaddr), .rd_a(rd_a), .rd_a_en(rd_a_en), .rd_b(rd_b), .rd_b_en(rd_b_en),
    .wr_reg(wr_reg), .wr_en(wr_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_size(mem_size),
    .mem_sext(mem_sext), .branch(branch), .halt(halt), .illegal(illegal), .prot_fault(prot_fault)
  );

  function automatic logic [31:0] rw(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [4:0] c, input logic [4:0] sh);
    return {op, a, b, c, sh, 6'h00};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] im);
    return {op, a, b, im};
  endfunction

  function automatic logic [28:0] ex(input logic [1:0] f, input logic il, input logic pf,
      input logic ae, input logic [4:0] a, input logic be, input logic [4:0] b,
      input logic we, input logic [4:0] w, input logic mr, input logic mw,
      input logic [1:0] sz, input logic sx, input logic br, input logic ht);
    return {f, il, pf, ae, a, be, b, we, w, mr, mw, sz, sx, br, ht};
  endfunction

  function automatic logic [28:0] bad(input logic [1:0] f);
    return ex(f, 1, 0, 0, N, 0, N, 0, N, 0, 0, 2'd0, 0, 0, 0);
  endfunction

  function automatic logic [28:0] flt(input logic [1:0] f);
    return ex(f, 0, 1, 0, N, 0, N, 0, N, 0, 0, 2'd0, 0, 0, 0);
  endfunction

  function automatic logic [28:0] pr(input logic [1:0] f, input logic ae, input logic [4:0] a,
      input logic be, input logic [4:0] b, input logic we, input logic [4:0] w);
    return ex(f, 0, 0, ae, a, be, b, we, w, 0, 0, 2'd0, 0, 0, 0);
  endfunction

  localparam int NV = 36;
  localparam logic [69:0] VEC [NV] = '{
    {8'd11, 1'b0, rw(6'h01, 5'd3, N, 5'd5, 5'd0),  pr(FR, 1, 5'd3, 0, N, 1, 5'd5)},       // R11 move
    {8'd4,  1'b0, rw(6'h01, 5'd3, 5'd2, 5'd5, 5'd0), bad(FR)},                            // R4 empty field filled
    {8'd4,  1'b0, rw(6'h01, N, N, 5'd5, 5'd0),      bad(FR)},                             // R4 required field empty
    {8'd11, 1'b0, rw(6'h19, 5'd1, 5'd2, 5'd4, 5'd0), pr(FR, 1, 5'd1, 1, 5'd2, 1, 5'd4)},  // R11 add
    {8'd3,  1'b0, rw(6'h19, 5'd1, 5'd2, 5'd4, 5'd3), bad(FR)},                            // R3 shift field on add
    {8'd12, 1'b0, rw(6'h17, N, N, 5'd6, 5'd4),      pr(FR, 1, 5'd6, 0, N, 1, 5'd6)},      // R12 literal amount
    {8'd12, 1'b0, rw(6'h18, N, 5'd7, 5'd6, 5'd0),   pr(FR, 1, 5'd6, 1, 5'd7, 1, 5'd6)},   // R12 register amount
    {8'd12, 1'b0, rw(6'h18, N, 5'd7, 5'd6, 5'd2),   bad(FR)},                             // R12 both amounts
    {8'd10, 1'b0, iw(6'h07, 5'd2, 5'd9, 16'h0040),  ex(FI, 0, 0, 1, 5'd2, 0, N, 1, 5'd9, 1, 0, 2'd2, 0, 0, 0)}, // R10 word load
    {8'd10, 1'b0, iw(6'h06, 5'd2, 5'd9, 16'h0000),  ex(FI, 0, 0, 1, 5'd2, 0, N, 1, 5'd9, 1, 0, 2'd1, 1, 0, 0)}, // R10 signed half
    {8'd10, 1'b0, iw(6'h08, 5'd1, 5'd2, 16'h0000),  ex(FI, 0, 0, 1, 5'd1, 1, 5'd2, 0, N, 0, 1, 2'd0, 0, 0, 0)}, // R10 byte store
    {8'd14, 1'b0, iw(6'h0E, N, N, 16'h0010),        ex(FI, 0, 0, 0, N, 0, N, 0, N, 0, 0, 2'd0, 0, 1, 0)},       // R14 jump, no base
    {8'd14, 1'b0, iw(6'h0D, 5'h13, N, 16'h0004),    ex(FI, 0, 0, 1, 5'h13, 0, N, 0, N, 0, 0, 2'd0, 0, 1, 0)},   // R14 jump with base
    {8'd2,  1'b0, rw(6'h27, N, N, N, 5'd0),         bad(FX)},                             // R2 first undefined
    {8'd2,  1'b0, 32'hFFFF_FFFF,                    bad(FX)},                             // R2 last undefined
    {8'd6,  1'b0, rw(6'h01, 5'h14, N, 5'd1, 5'd0),  flt(FR)},                             // R6 user reads table
    {8'd6,  1'b1, rw(6'h01, 5'h14, N, 5'd1, 5'd0),  pr(FR, 1, 5'h14, 0, N, 1, 5'd1)},     // R6 kernel reads table
    {8'd7,  1'b0, rw(6'h01, 5'd1, N, 5'h17, 5'd0),  flt(FR)},                             // R7 pc written
    {8'd7,  1'b0, rw(6'h01, 5'h17, N, 5'd1, 5'd0),  pr(FR, 1, 5'h17, 0, N, 1, 5'd1)},     // R7 pc read
    {8'd5,  1'b0, rw(6'h19, 5'h18, 5'd2, 5'd4, 5'd0), bad(FR)},                           // R5 undefined reg code
    {8'd8,  1'b0, rw(6'h01, 5'h14, 5'd2, 5'd1, 5'd0), bad(FR)},                           // R8 both, illegal wins
    {8'd13, 1'b0, iw(6'h22, N, N, 16'h0021),        pr(FI, 0, N, 0, N, 0, N)},            // R13 valid code
    {8'd13, 1'b0, iw(6'h22, N, N, 16'h0121),        bad(FI)},                             // R13 wide code
    {8'd14, 1'b0, rw(6'h24, N, N, N, 5'd0),         ex(FR, 0, 0, 0, N, 0, N, 0, N, 0, 0, 2'd0, 0, 0, 1)},       // R14 halt
    {8'd9,  1'b0, rw(6'h24, N, N, 5'd1, 5'd0),      bad(FR)},                             // R9 halt gated
    {8'd7,  1'b0, iw(6'h0B, N, 5'h17, 16'h1234),    flt(FI)},                             // R7 low load to pc
    {8'd11, 1'b0, iw(6'h0C, N, 5'd4, 16'hABCD),     pr(FI, 1, 5'd4, 0, N, 1, 5'd4)},      // R11 upper load
    {8'd11, 1'b0, iw(6'h25, 5'd1, 5'd1, 16'h000A),  pr(FI, 1, 5'd1, 0, N, 1, 5'd1)},      // R11 add immediate
    {8'd11, 1'b0, rw(6'h1D, 5'd2, N, 5'd3, 5'd0),   pr(FR, 1, 5'd2, 0, N, 1, 5'd3)},      // R11 invert
    {8'd11, 1'b0, rw(6'h15, N, N, 5'h16, 5'd0),     pr(FR, 1, 5'h16, 0, N, 1, 5'h16)},    // R11 increment
    {8'd11, 1'b0, rw(6'h14, 5'd1, 5'h16, N, 5'd0),  pr(FR, 1, 5'd1, 1, 5'h16, 0, N)},     // R11 compare
    {8'd3,  1'b0, iw(6'h07, 5'd2, 5'd9, 16'h07C0),  ex(FI, 0, 0, 1, 5'd2, 0, N, 1, 5'd9, 1, 0, 2'd2, 0, 0, 0)}, // R3 imm overlaps shift
    {8'd6,  1'b0, rw(6'h16, N, N, 5'h15, 5'd0),     flt(FR)},                             // R6 user decrements table
    {8'd6,  1'b1, rw(6'h16, N, N, 5'h15, 5'd0),     pr(FR, 1, 5'h15, 0, N, 1, 5'h15)},    // R6 kernel decrements
    {8'd5,  1'b0, iw(6'h0D, 5'h1E, N, 16'h0000),    bad(FI)},                             // R5 optional base undefined
    {8'd4,  1'b0, iw(6'h0D, N, 5'd3, 16'h0000),     bad(FI)}                              // R4 jump field B filled
  };

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [1:0] fmt_of(input logic [5:0] op);
    if (op > 6'h26) return FX;
    if (op <= 6'h02 || (op >= 6'h14 && op <= 6'h21) || op == 6'h23 || op == 6'h24) return FR;
    return FI;
  endfunction

  task automatic drive(input logic [31:0] w, input logic k);
    instr = w;
    kernel_mode = k;
    @(posedge clk);
    #(CLK_PERIOD / 4);
  endtask

  initial begin
    instr = 32'h0;
    kernel_mode = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    for (int i = 0; i < NV; i++) begin
      logic [28:0] got;
      drive(VEC[i][60:29], VEC[i][61]);
      got = {fmt, illegal, prot_fault, rd_a_en, rd_a, rd_b_en, rd_b, wr_en, wr_reg,
             mem_rd, mem_wr, mem_size, mem_sext, branch, halt};
      checks++;
      if (got !== VEC[i][28:0]) begin
        fails++;
        $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][69:62], i, got, VEC[i][28:0]);
      end
    end
    // R1 field slicing on an arbitrary word
    drive(32'h5E6F_ABCD, 1'b1);
    checks++;
    if ({opcode, shamt, imm, jaddr} !== {6'h17, 5'h0F, 16'hABCD, 26'h26F_ABCD}) begin
      fails++;
      $display("FAIL R1 fields: got %h expected %h", {opcode, shamt, imm, jaddr},
               {6'h17, 5'h0F, 16'hABCD, 26'h26F_ABCD});
    end
    // R1 format class of every opcode
    for (int op = 0; op < 64; op++) begin
      drive({op[5:0], 26'h3FF_FFC0}, 1'b0);
      checks++;
      if (fmt !== fmt_of(op[5:0])) begin
        fails++;
        $display("FAIL R1 format op %h: got %0d expected %0d", op, fmt, fmt_of(op[5:0]));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule